// File: doc/BRIEF.md
# Multi-Mode ADC Conversion Sequencer

This block is the digital sequencer placed in front of a successive-approximation converter with four analog inputs. Software sets a mode, a channel, a channel mask or a channel pair, and an interrupt enable, and then pulses a start. The sequencer then issues conversion requests to the converter one at a time over a start/done handshake. It writes each 8-bit result into a bank of four result slots and raises a sticky interrupt flag at the point the mode defines.

There are five modes. Two convert a single fixed channel: once, or repeatedly into a rotating ring of slots. Two walk a channel mask in ascending order: once, or pass after pass. The fifth alternates between two chosen channels and stores their results in a ping-pong pair. The continuous modes run until a stop request arrives. A stop lets the conversion in flight finish and store its result, and only then returns the sequencer to idle.

Top module: `adc_seq`

## Requirements
- R1: Mode code 0 (fixed single) converts the channel on `chan_i` exactly once. It stores the result in slot `chan_i` and then drops `busy_o`.
- R2: Mode code 1 (fixed continuous) converts `chan_i` repeatedly. The k-th result (counting from 0) goes to slot k mod 4, so the fifth result overwrites slot 0.
- R3: In mode 1 with `quad_irq_i` high at start, the interrupt is raised on every fourth result, which is the one written to slot 3. With `quad_irq_i` low, mode 1 never raises it.
- R4: Mode code 2 (scan single) converts every channel whose bit is set in `mask_i`, each once, in ascending index order. Each result goes to the slot with that channel's index. The interrupt is raised only with the result of the highest selected channel.
- R5: Mode 2 with a single mask bit set gives the same conversions, slots and interrupt as mode 0 on that channel.
- R6: Mode code 3 (scan continuous) repeats the mode 2 pass without end. After the highest selected channel it restarts at the lowest one, and it raises the interrupt once per pass.
- R7: Mode code 4 (dual) alternates between `dual_a_i` and `dual_b_i`, starting with A. A results go to slot 0 and B results to slot 1, and the interrupt is raised with each B result.
- R8: A `stop_i` pulse while busy lets the conversion in flight complete and be written. No further request is issued after it, and `busy_o` then falls.
- R9: A start with mode 2 or 3 and a zero mask, or with a mode code above 4, issues no conversion and leaves `busy_o` low.
- R10: `irq_o` stays set until `irq_clr_i` is high at a clock edge. An interrupt event on the same edge as a clear leaves it set.
- R11: Mode, channel, mask, pair, enables and `start_i` are taken only when idle. Changes to them while busy do not alter the running sequence.
- R12: With `irq_en_i` low at start, no mode raises `irq_o`.
- R13: After reset, all slots read zero and `irq_o`, `busy_o` and `cvt_start_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Mode code 0..4, sampled at start |
| chan_i | input | 2 | Fixed channel for modes 0 and 1 |
| mask_i | input | 4 | Channel mask for modes 2 and 3 |
| dual_a_i | input | 2 | First channel of the dual pair |
| dual_b_i | input | 2 | Second channel of the dual pair |
| irq_en_i | input | 1 | Interrupt enable, sampled at start |
| quad_irq_i | input | 1 | Interrupt every fourth result in mode 1 |
| start_i | input | 1 | Start pulse, accepted only when idle |
| stop_i | input | 1 | Stop request for the continuous modes |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| cvt_start_o | output | 1 | One-cycle conversion request |
| cvt_chan_o | output | 2 | Channel for the requested conversion |
| cvt_done_i | input | 1 | Converter result valid, one cycle |
| cvt_data_i | input | 8 | Converter result |
| res_o | output | 32 | Result slots, slot s at bits [8s+7:8s] |
| busy_o | output | 1 | Sequence running |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The bench targets the points where sequencing errors hide. The slot ring must wrap after four results; a design that fails to wrap would write past slot 3 or keep writing slot 0. The scan must restart at the lowest set bit rather than at channel 0, and the dual mode must not swap its A and B slots. A stop must arrive while a request is already in flight; a sequencer that stopped at once would lose that result, and one that ignored the stop would keep issuing requests. The bench also changes the configuration and pulses start again mid-run, holds the clear high across an interrupt event, and starts with a zero mask or an unused mode code; each of these exposes a design that re-samples its inputs, lets the clear win, or starts with nothing to convert.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    MODE_FIX_ONE  = 3'd0,
    MODE_FIX_RUN  = 3'd1,
    MODE_SCAN_ONE = 3'd2,
    MODE_SCAN_RUN = 3'd3,
    MODE_DUAL     = 3'd4
  } seq_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } seq_state_e;
endpackage

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
  parameter int N_CH = 4,
  parameter int CHW  = 2
) (
  input  logic [N_CH-1:0] mask_i,
  input  logic [CHW-1:0]  cur_i,
  output logic [CHW-1:0]  first_o,
  output logic [CHW-1:0]  next_o,
  output logic            has_next_o,
  output logic            any_o
);
  // downward walk leaves the lowest qualifying index
  always_comb begin
    first_o    = '0;
    next_o     = '0;
    has_next_o = 1'b0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        first_o = CHW'(i);
        if (CHW'(i) > cur_i) begin
          next_o     = CHW'(i);
          has_next_o = 1'b1;
        end
      end
    end
  end

  assign any_o = |mask_i;
endmodule

// File: rtl/adc_seq_bank.sv
module adc_seq_bank #(
  parameter int N_CH = 4,
  parameter int DW   = 8,
  parameter int CHW  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CHW-1:0]   wr_slot_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [N_CH*DW-1:0] res_o
);
  logic [DW-1:0] slot_q [N_CH];

  for (genvar s = 0; s < N_CH; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[s] <= '0;
      else if (wr_en_i && wr_slot_i == CHW'(s)) slot_q[s] <= wr_data_i;
    end
    assign res_o[s*DW +: DW] = slot_q[s];
  end

  a_r13_no_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(res_o));
endmodule

// File: rtl/adc_seq_irq.sv
module adc_seq_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> irq_o);
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !irq_o);
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int N_CH = 4,
  parameter int DW   = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [2:0]                mode_i,
  input  logic [$clog2(N_CH)-1:0]   chan_i,
  input  logic [N_CH-1:0]           mask_i,
  input  logic [$clog2(N_CH)-1:0]   dual_a_i,
  input  logic [$clog2(N_CH)-1:0]   dual_b_i,
  input  logic                      irq_en_i,
  input  logic                      quad_irq_i,
  input  logic                      start_i,
  input  logic                      stop_i,
  input  logic                      irq_clr_i,
  output logic                      cvt_start_o,
  output logic [$clog2(N_CH)-1:0]   cvt_chan_o,
  input  logic                      cvt_done_i,
  input  logic [DW-1:0]             cvt_data_i,
  output logic [N_CH*DW-1:0]        res_o,
  output logic                      busy_o,
  output logic                      irq_o
);
  localparam int CHW = $clog2(N_CH);
  localparam logic [CHW-1:0] LAST_SLOT = CHW'(N_CH - 1);

  seq_state_e     state_q;
  seq_mode_e      mode_q, mode_in;
  logic [CHW-1:0] chan_q, dual_a_q, dual_b_q, cur_q, rot_q;
  logic [N_CH-1:0] mask_q, pick_mask;
  logic           ien_q, quad_q, phase_q, stop_q, cvt_start_q;

  logic [CHW-1:0] first_ch, next_ch, start_ch, upcoming, wr_slot;
  logic           has_next, mask_any, cfg_ok, accept, done_hit;
  logic           is_scan, last_in_pass, finish, irq_evt;

  assign mode_in   = seq_mode_e'(mode_i);
  assign pick_mask = (state_q == ST_IDLE) ? mask_i : mask_q;

  adc_seq_pick #(.N_CH(N_CH), .CHW(CHW)) i_pick (
    .mask_i    (pick_mask),
    .cur_i     (cur_q),
    .first_o   (first_ch),
    .next_o    (next_ch),
    .has_next_o(has_next),
    .any_o     (mask_any)
  );

  always_comb begin
    case (mode_in)
      MODE_FIX_ONE, MODE_FIX_RUN, MODE_DUAL: cfg_ok = 1'b1;
      MODE_SCAN_ONE, MODE_SCAN_RUN:          cfg_ok = mask_any;
      default:                               cfg_ok = 1'b0;
    endcase
    case (mode_in)
      MODE_SCAN_ONE, MODE_SCAN_RUN: start_ch = first_ch;
      MODE_DUAL:                    start_ch = dual_a_i;
      default:                      start_ch = chan_i;
    endcase
  end

  assign accept       = (state_q == ST_IDLE) && start_i && cfg_ok;
  assign done_hit     = (state_q == ST_CONV) && cvt_done_i;
  assign is_scan      = (mode_q == MODE_SCAN_ONE) || (mode_q == MODE_SCAN_RUN);
  assign last_in_pass = is_scan && !has_next;

  always_comb begin
    case (mode_q)
      MODE_FIX_ONE: wr_slot = chan_q;
      MODE_FIX_RUN: wr_slot = rot_q;
      MODE_DUAL:    wr_slot = CHW'(phase_q);
      default:      wr_slot = cur_q;
    endcase
    case (mode_q)
      MODE_FIX_ONE: irq_evt = ien_q;
      MODE_FIX_RUN: irq_evt = ien_q && quad_q && (rot_q == LAST_SLOT);
      MODE_DUAL:    irq_evt = ien_q && phase_q;
      default:      irq_evt = ien_q && last_in_pass;
    endcase
    case (mode_q)
      MODE_FIX_RUN: upcoming = chan_q;
      MODE_DUAL:    upcoming = phase_q ? dual_a_q : dual_b_q;
      default:      upcoming = last_in_pass ? first_ch : next_ch;
    endcase
  end

  assign finish = stop_q || stop_i || (mode_q == MODE_FIX_ONE) ||
                  ((mode_q == MODE_SCAN_ONE) && last_in_pass);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      mode_q      <= MODE_FIX_ONE;
      chan_q      <= '0;
      mask_q      <= '0;
      dual_a_q    <= '0;
      dual_b_q    <= '0;
      ien_q       <= 1'b0;
      quad_q      <= 1'b0;
      cur_q       <= '0;
      rot_q       <= '0;
      phase_q     <= 1'b0;
      stop_q      <= 1'b0;
      cvt_start_q <= 1'b0;
    end else begin
      cvt_start_q <= 1'b0;
      if (accept) begin
        state_q     <= ST_CONV;
        mode_q      <= mode_in;
        chan_q      <= chan_i;
        mask_q      <= mask_i;
        dual_a_q    <= dual_a_i;
        dual_b_q    <= dual_b_i;
        ien_q       <= irq_en_i;
        quad_q      <= quad_irq_i;
        cur_q       <= start_ch;
        rot_q       <= '0;
        phase_q     <= 1'b0;
        stop_q      <= 1'b0;
        cvt_start_q <= 1'b1;
      end else if (state_q == ST_CONV) begin
        if (stop_i) stop_q <= 1'b1;
        if (done_hit) begin
          rot_q   <= (rot_q == LAST_SLOT) ? '0 : rot_q + 1'b1;
          phase_q <= ~phase_q;
          if (finish) begin
            state_q <= ST_IDLE;
          end else begin
            cur_q       <= upcoming;
            cvt_start_q <= 1'b1;
          end
        end
      end
    end
  end

  adc_seq_bank #(.N_CH(N_CH), .DW(DW), .CHW(CHW)) i_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (done_hit),
    .wr_slot_i(wr_slot),
    .wr_data_i(cvt_data_i),
    .res_o    (res_o)
  );

  adc_seq_irq i_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (done_hit && irq_evt),
    .clr_i (irq_clr_i),
    .irq_o (irq_o)
  );

  assign cvt_start_o = cvt_start_q;
  assign cvt_chan_o  = cur_q;
  assign busy_o      = (state_q == ST_CONV);

  a_r1_single_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mode_q == MODE_FIX_ONE && cvt_done_i) |=> (!busy_o && !cvt_start_o));
  a_r8_stop_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (stop_q || stop_i) && cvt_done_i) |=> (!busy_o && !cvt_start_o));
  a_r8_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cvt_start_o |=> !cvt_start_o);
  a_r9_bad_mode_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && mode_i > 3'd4) |=> (!busy_o && !cvt_start_o));
  a_r11_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(mode_q) && $stable(mask_q) && $stable(chan_q)));
  a_r6_scan_in_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cvt_start_o && (mode_q == MODE_SCAN_RUN || mode_q == MODE_SCAN_ONE))
      |-> mask_q[cvt_chan_o]);
endmodule

// File: tb/test_adc_seq.sv
module test_adc_seq;
  localparam int N_CH = 4;
  localparam int DW   = 8;

  typedef struct packed {
    logic [7:0] req;
    logic [1:0] ch;
    logic [1:0] slot;
    logic       irq;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] mode_i = '0;
  logic [1:0] chan_i = '0, dual_a_i = '0, dual_b_i = '0;
  logic [3:0] mask_i = '0;
  logic irq_en_i = 1'b0, quad_irq_i = 1'b0, start_i = 1'b0, stop_i = 1'b0;
  logic irq_clr_i;
  logic cvt_start_o, cvt_done_i = 1'b0, busy_o, irq_o;
  logic [1:0] cvt_chan_o;
  logic [7:0] cvt_data_i = '0;
  logic [N_CH*DW-1:0] res_o;

  logic force_clr = 1'b0, auto_pulse = 1'b0, auto_clr = 1'b1;
  assign irq_clr_i = force_clr | auto_pulse;

  int n_chk = 0, n_fail = 0, pops = 0, cycles = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  adc_seq #(.N_CH(N_CH), .DW(DW)) i_adc_seq (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .chan_i(chan_i), .mask_i(mask_i),
    .dual_a_i(dual_a_i), .dual_b_i(dual_b_i), .irq_en_i(irq_en_i), .quad_irq_i(quad_irq_i),
    .start_i(start_i), .stop_i(stop_i), .irq_clr_i(irq_clr_i), .cvt_start_o(cvt_start_o),
    .cvt_chan_o(cvt_chan_o), .cvt_done_i(cvt_done_i), .cvt_data_i(cvt_data_i),
    .res_o(res_o), .busy_o(busy_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: latency 2..4 cycles, data tags channel and sequence number
  logic [1:0] m_chan = '0;
  int m_cnt = 0, m_seq = 0;
  always @(posedge clk) begin
    cvt_done_i <= 1'b0;
    if (rst_ni) begin
      if (cvt_start_o) begin
        m_chan <= cvt_chan_o;
        m_cnt  <= 2 + (m_seq % 3);
      end else if (m_cnt != 0) begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == 1) begin
          cvt_done_i <= 1'b1;
          cvt_data_i <= {m_chan, 6'(m_seq)};
          m_seq      <= m_seq + 1;
        end
      end
    end
  end

  // monitor: compare each stored result with the head of the scoreboard
  logic       p_valid = 1'b0;
  logic [7:0] p_data = '0;
  always @(negedge clk) begin
    if (p_valid) begin
      p_valid = 1'b0;
      if (q.size() == 0) begin
        check(1'b0, "R8 unexpected conversion", 1, 0);
      end else begin
        exp_t e;
        string tag;
        e = q.pop_front();
        tag = $sformatf("R%0d", e.req);
        check(p_data[7:6] == e.ch, {tag, " channel"}, p_data[7:6], e.ch);
        check(res_o[e.slot*DW +: DW] == p_data, {tag, " slot data"},
              res_o[e.slot*DW +: DW], p_data);
        check(irq_o == e.irq, {tag, " irq"}, irq_o, e.irq);
        pops++;
      end
    end
    if (rst_ni && cvt_done_i) begin
      p_valid = 1'b1;
      p_data  = cvt_data_i;
    end
    auto_pulse = auto_clr && irq_o;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic void push(int req, int ch, int slot, bit irq);
    exp_t e;
    e.req = 8'(req); e.ch = 2'(ch); e.slot = 2'(slot); e.irq = irq;
    q.push_back(e);
  endfunction

  task automatic start_run(int md, int ch, int mk, int a, int b, bit ien, bit quad);
    @(negedge clk);
    mode_i = 3'(md); chan_i = 2'(ch); mask_i = 4'(mk); dual_a_i = 2'(a); dual_b_i = 2'(b);
    irq_en_i = ien; quad_irq_i = quad; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic stop_at(int target);
    wait (pops == target);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
  endtask

  task automatic end_run(string req);
    wait_idle();
    repeat (12) @(negedge clk);
    check(q.size() == 0, req, q.size(), 0);
    check(!busy_o, req, busy_o, 0);
  endtask

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R13 reset state
    check(res_o == '0, "R13 results", int'(res_o), 0);
    check(!irq_o, "R13 irq", irq_o, 0);
    check(!busy_o, "R13 busy", busy_o, 0);
    check(!cvt_start_o, "R13 request", cvt_start_o, 0);

    // R1 fixed single on channel 3
    push(1, 3, 3, 1);
    start_run(0, 3, 0, 0, 0, 1, 0);
    end_run("R1 single done");

    // R12 no interrupt when disabled
    push(12, 1, 1, 0);
    start_run(0, 1, 0, 0, 0, 0, 0);
    end_run("R12 idle");

    // R5 one-bit scan behaves as fixed single on channel 2
    push(5, 2, 2, 1);
    start_run(2, 0, 4'b0100, 0, 0, 1, 0);
    end_run("R5 idle");

    // R2/R3 rotating slots with interrupt every fourth, stopped after 9
    base = pops;
    for (int k = 0; k < 9; k++) push(2, 2, k % 4, (k % 4) == 3);
    start_run(1, 2, 0, 0, 0, 1, 1);
    stop_at(base + 8);  // R8 stop while ninth is in flight
    end_run("R8 fixed continuous stop");

    // R3 no interrupt without the quad enable
    base = pops;
    for (int k = 0; k < 5; k++) push(3, 0, k % 4, 0);
    start_run(1, 0, 0, 0, 0, 1, 0);
    stop_at(base + 4);
    end_run("R3 quad off stop");

    // R4 scan single over channels 0,1,3
    push(4, 0, 0, 0); push(4, 1, 1, 0); push(4, 3, 3, 1);
    start_run(2, 0, 4'b1011, 0, 0, 1, 0);
    end_run("R4 scan single done");

    // R6 scan continuous over 1,3 for three passes; R11 mid-run changes ignored
    base = pops;
    for (int p = 0; p < 3; p++) begin
      push(6, 1, 1, 0);
      push(6, 3, 3, 1);
    end
    start_run(3, 0, 4'b1010, 0, 0, 1, 0);
    wait (pops == base + 1);
    start_run(0, 2, 4'b1111, 0, 0, 0, 0);  // R11 restart attempt while busy
    stop_at(base + 5);
    end_run("R6 scan continuous stop");

    // R7 dual pair A=3, B=1
    base = pops;
    for (int p = 0; p < 3; p++) begin
      push(7, 3, 0, 0);
      push(7, 1, 1, 1);
    end
    start_run(4, 0, 0, 3, 1, 1, 0);
    stop_at(base + 5);
    end_run("R7 dual stop");

    // R9 zero mask and unused mode code
    start_run(3, 0, 4'b0000, 0, 0, 1, 0);
    repeat (3) @(negedge clk);
    check(!busy_o && !cvt_start_o, "R9 zero mask", busy_o, 0);
    start_run(6, 1, 4'b1111, 0, 0, 1, 0);
    repeat (3) @(negedge clk);
    check(!busy_o && !cvt_start_o, "R9 bad mode", busy_o, 0);
    repeat (10) @(negedge clk);
    check(q.size() == 0, "R9 no conversions", q.size(), 0);

    // R10 sticky flag, then explicit clear
    auto_clr = 1'b0;
    push(10, 0, 0, 1);
    start_run(0, 0, 0, 0, 0, 1, 0);
    wait_idle();
    repeat (5) @(negedge clk);
    check(irq_o, "R10 sticky", irq_o, 1);
    force_clr = 1'b1;
    @(negedge clk);
    force_clr = 1'b0;
    check(!irq_o, "R10 cleared", irq_o, 0);

    // R10 clear held across the event: set must win
    force_clr = 1'b1;
    push(10, 1, 1, 1);
    start_run(0, 1, 0, 0, 0, 1, 0);
    wait_idle();
    check(!irq_o, "R10 cleared after event", irq_o, 0);
    force_clr = 1'b0;
    check(q.size() == 0, "R10 queue", q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule